// File: doc/BRIEF.md
# Dual-Channel General-Purpose I/O with Change Interrupt

This block is a general-purpose I/O peripheral reached through an AXI4-Lite slave port. It has a primary channel and an optional secondary channel, and each channel is sized on its own from 1 to 32 pins. Every pin has a data output, a high-impedance control and an input. A per-bit direction register selects whether the pin drives its output latch or floats so that the outside world can drive it. Each channel can instead be built as input-only or output-only, and then its direction is fixed.

Inputs cross into the clock domain through a two-flop synchronizer. A third flop keeps the previous synchronized value, so any toggle on a pin currently set as an input can be seen. Each channel owns one sticky status bit, which is set by such a toggle and cleared by writing a one to it. The two status bits are masked by per-channel enables and by a global enable, and the result drives one shared interrupt line. The interrupt logic is a build option.

Reset values of the output latches and the direction registers come from per-bit parameters, so a board can start with a known drive pattern before software runs.

Top module: `dual_pio`

## Requirements
- R1: After reset, channel 0's output latch holds CH0_OUT_INIT and its direction register holds CH0_DIR_INIT. This state is visible on ch0_out and ch0_hiz and in register reads. The interrupt status reads zero.
- R2: Writing word offset 0x000 (channel 1: 0x008) updates the output latch, which drives chN_out. Reading that offset returns, for each bit, the synchronized pin value where the direction bit is 1 and the latch value where it is 0.
- R3: Offset 0x004 (channel 1: 0x00C) is the direction register. A 1 sets the pin to input (chN_hiz bit high) and a 0 sets it to driven output. chN_hiz changes only on a write to that offset.
- R4: Writes honour s_wstrb. Byte lane k of a register changes only when s_wstrb[k] is 1.
- R5: A channel built input-only has all direction bits reading 1, drives chN_hiz all ones and chN_out all zeros, and ignores direction writes.
- R6: A channel built output-only has all direction bits reading 0 and chN_hiz all zeros. Its data reads return the latch whatever the pin inputs do.
- R7: With HAS_CH1 = 0, offsets 0x008 and 0x00C read zero and writes to them have no effect.
- R8: A transition in either direction on any pin whose direction bit is 1 sets that channel's status bit: bit 0 for channel 0 and bit 1 for channel 1, at offset 0x120. Transitions on pins set as outputs set nothing.
- R9: A status bit stays set until a write to 0x120 with a 1 in that bit position. Writing 0 leaves it unchanged.
- R10: irq is high exactly when the global enable (bit 31 of 0x11C) is 1 and some channel has both its status bit and its enable bit (bits 0 and 1 of 0x128) set.
- R11: With HAS_IRQ = 0, offsets 0x11C, 0x120 and 0x128 read zero and irq stays low.
- R12: Every write response and read response is OKAY (00). Unmapped offsets read zero. A pending response and its read data are held until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_awaddr | input | 9 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address accepted |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data accepted |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response accepted |
| s_araddr | input | 9 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address accepted |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data accepted |
| ch0_in | input | CH0_W | Channel 0 pin inputs |
| ch0_out | output | CH0_W | Channel 0 output latch |
| ch0_hiz | output | CH0_W | Channel 0 high-impedance control, 1 = input |
| ch1_in | input | CH1_W | Channel 1 pin inputs |
| ch1_out | output | CH1_W | Channel 1 output latch |
| ch1_hiz | output | CH1_W | Channel 1 high-impedance control, 1 = input |
| irq | output | 1 | Shared interrupt request |

## Verification
The bench builds two instances on one shared bus. The main instance has an 8-bit channel 0 with a mixed direction reset (0x0F) and a distinctive latch reset (0xA5). Its channel 1 is 5 bits wide, built input-only, and the interrupt logic is present, which brings in the full status, enable and global-gate paths and the rule that output pins are filtered from change detection. The second instance has only a 4-bit output-only channel and no interrupt logic, which exercises the absent-channel and absent-interrupt read-zero behaviour and the latch-only read path under identical bus traffic.

// File: rtl/dual_pio_pkg.sv
package dual_pio_pkg;

   localparam int ADDR_W = 9;
   localparam int DATA_W = 32;
   localparam int NUM_CH = 2;

   localparam logic [ADDR_W-1:0] OFS_C0_DATA = 9'h000;
   localparam logic [ADDR_W-1:0] OFS_C0_DIR  = 9'h004;
   localparam logic [ADDR_W-1:0] OFS_C1_DATA = 9'h008;
   localparam logic [ADDR_W-1:0] OFS_C1_DIR  = 9'h00C;
   localparam logic [ADDR_W-1:0] OFS_GIE     = 9'h11C;
   localparam logic [ADDR_W-1:0] OFS_STAT    = 9'h120;
   localparam logic [ADDR_W-1:0] OFS_ENA     = 9'h128;

   localparam logic [1:0] RESP_OKAY = 2'b00;

   // Expands byte strobes into a per-bit write mask.
   function automatic logic [DATA_W-1:0] strobe_to_mask(input logic [DATA_W/8-1:0] strb);
      logic [DATA_W-1:0] m;
      for (int b = 0; b < DATA_W/8; b++) begin
         m[b*8 +: 8] = {8{strb[b]}};
      end
      return m;
   endfunction

endpackage

// File: rtl/pio_axil_slave.sv
module pio_axil_slave
   import dual_pio_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] awaddr,
   input  logic              awvalid,
   output logic              awready,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W/8-1:0] wstrb,
   input  logic              wvalid,
   output logic              wready,
   output logic [1:0]        bresp,
   output logic              bvalid,
   input  logic              bready,
   input  logic [ADDR_W-1:0] araddr,
   input  logic              arvalid,
   output logic              arready,
   output logic [DATA_W-1:0] rdata,
   output logic [1:0]        rresp,
   output logic              rvalid,
   input  logic              rready,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] wr_mask,
   output logic [ADDR_W-1:0] rd_addr,
   input  logic [DATA_W-1:0] rd_value
);

   logic rd_en;

   // A write is taken when address and data arrive together and no response is pending.
   assign wr_en   = awvalid & wvalid & ~bvalid;
   assign awready = wr_en;
   assign wready  = wr_en;
   assign wr_addr = awaddr;
   assign wr_data = wdata;
   assign wr_mask = strobe_to_mask(wstrb);
   assign bresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n)      bvalid <= 1'b0;
      else if (wr_en)  bvalid <= 1'b1;
      else if (bready) bvalid <= 1'b0;
   end

   assign rd_en   = arvalid & ~rvalid;
   assign arready = rd_en;
   assign rd_addr = araddr;
   assign rresp   = RESP_OKAY;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid <= 1'b0;
         rdata  <= '0;
      end else if (rd_en) begin
         rvalid <= 1'b1;
         rdata  <= rd_value;
      end else if (rready) begin
         rvalid <= 1'b0;
      end
   end

endmodule

// File: rtl/pio_channel.sv
module pio_channel
   import dual_pio_pkg::*;
#(
   parameter int          W        = 32,
   parameter bit          PRESENT  = 1'b1,
   parameter bit          IN_ONLY  = 1'b0,
   parameter bit          OUT_ONLY = 1'b0,
   parameter logic [31:0] OUT_INIT = '0,
   parameter logic [31:0] DIR_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_data,
   input  logic              we_dir,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wmask,
   input  logic [W-1:0]      pin_in,
   output logic [W-1:0]      pin_out,
   output logic [W-1:0]      pin_hiz,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] rd_dir,
   output logic              changed
);

   if (W < 1 || W > DATA_W) begin : g_bad_width
      $error("pio_channel: W must lie in 1..32");
   end
   if (IN_ONLY && OUT_ONLY) begin : g_bad_mode
      $error("pio_channel: input-only and output-only are exclusive");
   end

   if (!PRESENT) begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk, rst_n, we_data, we_dir, wdata, wmask, pin_in};
      assign pin_out = '0;
      assign pin_hiz = '1;
      assign rd_data = '0;
      assign rd_dir  = '0;
      assign changed = 1'b0;
   end else begin : g_present
      logic [W-1:0] out_q, dir_q, dir_eff;
      logic [W-1:0] sync1_q, sync2_q, hist_q, seen;
      logic [W-1:0] m;
      logic         unused_hi;

      assign m         = wmask[W-1:0];
      assign unused_hi = ^{wdata, wmask, dir_q, out_q};

      always_ff @(posedge clk) begin
         if (!rst_n)       out_q <= W'(OUT_INIT);
         else if (we_data) out_q <= (out_q & ~m) | (wdata[W-1:0] & m);
      end

      always_ff @(posedge clk) begin
         if (!rst_n)      dir_q <= W'(DIR_INIT);
         else if (we_dir) dir_q <= (dir_q & ~m) | (wdata[W-1:0] & m);
      end

      // Two-flop synchronizer plus one history stage for toggle detection.
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sync1_q <= '0;
            sync2_q <= '0;
            hist_q  <= '0;
         end else begin
            sync1_q <= pin_in;
            sync2_q <= sync1_q;
            hist_q  <= sync2_q;
         end
      end

      if (IN_ONLY) begin : g_in_only
         assign dir_eff = '1;
         assign pin_out = '0;
      end else if (OUT_ONLY) begin : g_out_only
         assign dir_eff = '0;
         assign pin_out = out_q;
      end else begin : g_bidir
         assign dir_eff = dir_q;
         assign pin_out = out_q;
      end

      assign seen    = (dir_eff & sync2_q) | (~dir_eff & out_q);
      assign pin_hiz = dir_eff;
      assign rd_data = DATA_W'(seen);
      assign rd_dir  = DATA_W'(dir_eff);
      assign changed = |((sync2_q ^ hist_q) & dir_eff);
   end

endmodule

// File: rtl/pio_irq.sv
module pio_irq
   import dual_pio_pkg::*;
#(
   parameter bit PRESENT = 1'b1,
   parameter int NCH     = NUM_CH
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_gie,
   input  logic              we_stat,
   input  logic              we_ena,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] wmask,
   input  logic [NCH-1:0]    changed,
   output logic              gie_q,
   output logic [NCH-1:0]    stat_q,
   output logic [NCH-1:0]    ena_q,
   output logic              irq
);

   if (NCH < 1 || NCH > DATA_W - 1) begin : g_bad_nch
      $error("pio_irq: NCH out of range");
   end

   if (!PRESENT) begin : g_absent
      logic unused_in;
      assign unused_in = ^{clk, rst_n, we_gie, we_stat, we_ena, wdata, wmask, changed};
      assign gie_q  = 1'b0;
      assign stat_q = '0;
      assign ena_q  = '0;
      assign irq    = 1'b0;
   end else begin : g_present
      logic [NCH-1:0] wbits, mbits, clr;
      logic           unused_hi;

      assign wbits     = wdata[NCH-1:0];
      assign mbits     = wmask[NCH-1:0];
      assign clr       = we_stat ? (wbits & mbits) : '0;
      assign unused_hi = ^{wdata, wmask};

      always_ff @(posedge clk) begin
         if (!rst_n)                         gie_q <= 1'b0;
         else if (we_gie && wmask[DATA_W-1]) gie_q <= wdata[DATA_W-1];
      end

      always_ff @(posedge clk) begin
         if (!rst_n)      ena_q <= '0;
         else if (we_ena) ena_q <= (ena_q & ~mbits) | (wbits & mbits);
      end

      // A new toggle wins over a clear in the same cycle.
      always_ff @(posedge clk) begin
         if (!rst_n) stat_q <= '0;
         else        stat_q <= (stat_q & ~clr) | changed;
      end

      assign irq = gie_q & (|(stat_q & ena_q));
   end

endmodule

// File: rtl/dual_pio.sv
module dual_pio
   import dual_pio_pkg::*;
#(
   parameter int          CH0_W        = 32,
   parameter int          CH1_W        = 32,
   parameter bit          HAS_CH1      = 1'b0,
   parameter bit          HAS_IRQ      = 1'b0,
   parameter bit          CH0_IN_ONLY  = 1'b0,
   parameter bit          CH0_OUT_ONLY = 1'b0,
   parameter bit          CH1_IN_ONLY  = 1'b0,
   parameter bit          CH1_OUT_ONLY = 1'b0,
   parameter logic [31:0] CH0_OUT_INIT = '0,
   parameter logic [31:0] CH0_DIR_INIT = '1,
   parameter logic [31:0] CH1_OUT_INIT = '0,
   parameter logic [31:0] CH1_DIR_INIT = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [8:0]        s_awaddr,
   input  logic              s_awvalid,
   output logic              s_awready,
   input  logic [31:0]       s_wdata,
   input  logic [3:0]        s_wstrb,
   input  logic              s_wvalid,
   output logic              s_wready,
   output logic [1:0]        s_bresp,
   output logic              s_bvalid,
   input  logic              s_bready,
   input  logic [8:0]        s_araddr,
   input  logic              s_arvalid,
   output logic              s_arready,
   output logic [31:0]       s_rdata,
   output logic [1:0]        s_rresp,
   output logic              s_rvalid,
   input  logic              s_rready,
   input  logic [CH0_W-1:0]  ch0_in,
   output logic [CH0_W-1:0]  ch0_out,
   output logic [CH0_W-1:0]  ch0_hiz,
   input  logic [CH1_W-1:0]  ch1_in,
   output logic [CH1_W-1:0]  ch1_out,
   output logic [CH1_W-1:0]  ch1_hiz,
   output logic              irq
);

   localparam int NCH = NUM_CH;

   logic              wr_en;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [DATA_W-1:0] wr_data, wr_mask, rd_value;
   logic [DATA_W-1:0] c0_data, c0_dir, c1_data, c1_dir;
   logic [NCH-1:0]    chg;
   logic              irq_gie_q;
   logic [NCH-1:0]    irq_stat_q, irq_ena_q;

   pio_axil_slave u_bus (
      .clk(clk), .rst_n(rst_n),
      .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
      .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
      .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
      .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
      .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask),
      .rd_addr(rd_addr), .rd_value(rd_value)
   );

   pio_channel #(
      .W(CH0_W), .PRESENT(1'b1), .IN_ONLY(CH0_IN_ONLY), .OUT_ONLY(CH0_OUT_ONLY),
      .OUT_INIT(CH0_OUT_INIT), .DIR_INIT(CH0_DIR_INIT)
   ) u_ch0 (
      .clk(clk), .rst_n(rst_n),
      .we_data(wr_en && wr_addr == OFS_C0_DATA),
      .we_dir (wr_en && wr_addr == OFS_C0_DIR),
      .wdata(wr_data), .wmask(wr_mask),
      .pin_in(ch0_in), .pin_out(ch0_out), .pin_hiz(ch0_hiz),
      .rd_data(c0_data), .rd_dir(c0_dir), .changed(chg[0])
   );

   pio_channel #(
      .W(CH1_W), .PRESENT(HAS_CH1), .IN_ONLY(CH1_IN_ONLY), .OUT_ONLY(CH1_OUT_ONLY),
      .OUT_INIT(CH1_OUT_INIT), .DIR_INIT(CH1_DIR_INIT)
   ) u_ch1 (
      .clk(clk), .rst_n(rst_n),
      .we_data(wr_en && wr_addr == OFS_C1_DATA),
      .we_dir (wr_en && wr_addr == OFS_C1_DIR),
      .wdata(wr_data), .wmask(wr_mask),
      .pin_in(ch1_in), .pin_out(ch1_out), .pin_hiz(ch1_hiz),
      .rd_data(c1_data), .rd_dir(c1_dir), .changed(chg[1])
   );

   pio_irq #(.PRESENT(HAS_IRQ), .NCH(NCH)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .we_gie (wr_en && wr_addr == OFS_GIE),
      .we_stat(wr_en && wr_addr == OFS_STAT),
      .we_ena (wr_en && wr_addr == OFS_ENA),
      .wdata(wr_data), .wmask(wr_mask), .changed(chg),
      .gie_q(irq_gie_q), .stat_q(irq_stat_q), .ena_q(irq_ena_q), .irq(irq)
   );

   always_comb begin
      case (rd_addr)
         OFS_C0_DATA: rd_value = c0_data;
         OFS_C0_DIR:  rd_value = c0_dir;
         OFS_C1_DATA: rd_value = c1_data;
         OFS_C1_DIR:  rd_value = c1_dir;
         OFS_GIE:     rd_value = {irq_gie_q, {(DATA_W-1){1'b0}}};
         OFS_STAT:    rd_value = DATA_W'(irq_stat_q);
         OFS_ENA:     rd_value = DATA_W'(irq_ena_q);
         default:     rd_value = '0;
      endcase
   end

endmodule

// File: rtl/dual_pio_checker.sv
module dual_pio_checker #(
   parameter int CH0_W = 32
) (
   input logic             clk,
   input logic             rst_n,
   input logic [8:0]       awaddr,
   input logic             awready,
   input logic             bvalid,
   input logic             bready,
   input logic             rvalid,
   input logic             rready,
   input logic [31:0]      rdata,
   input logic [CH0_W-1:0] ch0_out,
   input logic [CH0_W-1:0] ch0_hiz,
   input logic             irq,
   input logic             gie,
   input logic [1:0]       stat
);

   p_bresp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      bvalid && !bready |=> bvalid);

   p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rvalid && !rready |=> rvalid && $stable(rdata));

   p_latch_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !(awready && awaddr == 9'h000) |=> $stable(ch0_out));

   p_dir_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !(awready && awaddr == 9'h004) |=> $stable(ch0_hiz));

   p_stat0_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat[0] && !(awready && awaddr == 9'h120) |=> stat[0]);

   p_stat1_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      stat[1] && !(awready && awaddr == 9'h120) |=> stat[1]);

   p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !gie |-> !irq);

endmodule

bind dual_pio dual_pio_checker #(.CH0_W(CH0_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .awaddr(s_awaddr), .awready(s_awready),
   .bvalid(s_bvalid), .bready(s_bready), .rvalid(s_rvalid), .rready(s_rready),
   .rdata(s_rdata), .ch0_out(ch0_out), .ch0_hiz(ch0_hiz), .irq(irq),
   .gie(irq_gie_q), .stat(irq_stat_q)
);

// File: tb/dual_pio_test.sv
`timescale 1ns/1ps
module dual_pio_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic [8:0]  awaddr = '0, araddr = '0;
   logic        awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
   logic [31:0] wdata = '0;
   logic [3:0]  wstrb = '0;

   logic        awready_u, wready_u, bvalid_u, arready_u, rvalid_u, irq_u;
   logic [1:0]  bresp_u, rresp_u;
   logic [31:0] rdata_u;
   logic        awready_m, wready_m, bvalid_m, arready_m, rvalid_m, irq_m;
   logic [1:0]  bresp_m, rresp_m;
   logic [31:0] rdata_m;

   logic [7:0] p0 = '0, c0_out, c0_hiz;
   logic [4:0] p1 = '0, c1_out, c1_hiz;
   logic [3:0] q0 = '0, d0_out, d0_hiz;
   logic [2:0] q1 = '0, d1_out, d1_hiz;

   dual_pio #(
      .CH0_W(8), .CH1_W(5), .HAS_CH1(1'b1), .HAS_IRQ(1'b1), .CH1_IN_ONLY(1'b1),
      .CH0_OUT_INIT(32'hA5), .CH0_DIR_INIT(32'h0F), .CH1_OUT_INIT(32'h1F)
   ) uut (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready_u),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready_u),
      .s_bresp(bresp_u), .s_bvalid(bvalid_u), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready_u),
      .s_rdata(rdata_u), .s_rresp(rresp_u), .s_rvalid(rvalid_u), .s_rready(rready),
      .ch0_in(p0), .ch0_out(c0_out), .ch0_hiz(c0_hiz),
      .ch1_in(p1), .ch1_out(c1_out), .ch1_hiz(c1_hiz), .irq(irq_u)
   );

   dual_pio #(
      .CH0_W(4), .CH1_W(3), .HAS_CH1(1'b0), .HAS_IRQ(1'b0), .CH0_OUT_ONLY(1'b1),
      .CH0_OUT_INIT(32'h9)
   ) uut_min (
      .clk(clk), .rst_n(rst_n),
      .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready_m),
      .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready_m),
      .s_bresp(bresp_m), .s_bvalid(bvalid_m), .s_bready(bready),
      .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready_m),
      .s_rdata(rdata_m), .s_rresp(rresp_m), .s_rvalid(rvalid_m), .s_rready(rready),
      .ch0_in(q0), .ch0_out(d0_out), .ch0_hiz(d0_hiz),
      .ch1_in(q1), .ch1_out(d1_out), .ch1_hiz(d1_hiz), .irq(irq_m)
   );

   int checks = 0, errors = 0;
   logic [31:0] rd_u, rd_m;
   logic [1:0]  last_rresp, last_bresp;
   logic        last_bvalid;

   logic [7:0] exp_out0 = 8'hA5, exp_dir0 = 8'h0F;
   logic [3:0] exp_mout = 4'h9;
   logic       exp_gie = 0;
   logic [1:0] exp_ena = 0, exp_stat = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] merge(input logic [31:0] old, input logic [31:0] nw,
                                         input logic [3:0] s);
      logic [31:0] m;
      for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{s[b]}};
      return (old & ~m) | (nw & m);
   endfunction

   function automatic logic [7:0] view0(input logic [7:0] dir, input logic [7:0] lat,
                                        input logic [7:0] pins);
      return (dir & pins) | (~dir & lat);
   endfunction

   function automatic logic exp_irq();
      return exp_gie & (|(exp_stat & exp_ena));
   endfunction

   task automatic bus_write(input logic [8:0] a, input logic [31:0] d, input logic [3:0] s);
      @(negedge clk);
      awaddr = a; wdata = d; wstrb = s; awvalid = 1; wvalid = 1;
      @(negedge clk);
      awvalid = 0; wvalid = 0; bready = 1;
      last_bresp = bresp_u; last_bvalid = bvalid_u;
      @(negedge clk);
      bready = 0;
   endtask

   task automatic bus_read(input logic [8:0] a);
      @(negedge clk);
      araddr = a; arvalid = 1;
      @(negedge clk);
      arvalid = 0; rready = 1;
      rd_u = rdata_u; rd_m = rdata_m; last_rresp = rresp_u;
      @(negedge clk);
      rready = 0;
   endtask

   task automatic settle();
      repeat (5) @(negedge clk);
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
   end

   initial begin
      void'($urandom(32'd4711));
      repeat (4) @(negedge clk);
      rst_n = 1;
      settle();

      // R1 reset state
      chk("R1 ch0_out", 32'(c0_out), 32'hA5);
      chk("R1 ch0_hiz", 32'(c0_hiz), 32'h0F);
      bus_read(9'h004); chk("R1 dir read", rd_u, 32'h0F);
      bus_read(9'h000); chk("R1 data read", rd_u, 32'hA0);
      bus_read(9'h120); chk("R1 status", rd_u, 32'h0);

      // R11 interrupt logic absent in uut_min
      bus_read(9'h11C); chk("R11 gie absent", rd_m, 0);
      bus_read(9'h128); chk("R11 ena absent", rd_m, 0);

      // R5 input-only channel 1
      chk("R5 ch1_hiz", 32'(c1_hiz), 32'h1F);
      chk("R5 ch1_out", 32'(c1_out), 32'h0);
      bus_write(9'h00C, 32'h0, 4'hF);
      bus_read(9'h00C); chk("R5 dir write ignored", rd_u, 32'h1F);
      chk("R5 ch1_hiz after write", 32'(c1_hiz), 32'h1F);

      // R7 absent channel in uut_min
      bus_write(9'h008, 32'h7, 4'hF);
      bus_read(9'h008); chk("R7 absent data", rd_m, 0);
      bus_read(9'h00C); chk("R7 absent dir", rd_m, 0);
      chk("R7 absent pins", 32'(d1_out), 0);

      // R4 byte strobes
      bus_write(9'h000, 32'hFFFF_FF3C, 4'b0010);
      chk("R4 lane0 masked", 32'(c0_out), {24'h0, exp_out0});
      chk("R4 lane0 masked min", 32'(d0_out), {28'h0, exp_mout});
      bus_write(9'h000, 32'hFFFF_FF3C, 4'b0001);
      exp_out0 = 8'h3C; exp_mout = 4'hC;
      chk("R4 lane0 written", 32'(c0_out), 32'h3C);

      // R6 output-only channel ignores pins and direction writes
      q0 = 4'hF;
      bus_write(9'h004, 32'hF, 4'hF);
      exp_dir0 = 8'h0F;
      settle();
      chk("R6 hiz zero", 32'(d0_hiz), 0);
      bus_read(9'h004); chk("R6 dir zero", rd_m, 0);
      bus_read(9'h000); chk("R6 latch read", rd_m, 32'hC);

      // R8 change detection, R9 clear
      p0 = 8'h40; settle();
      bus_read(9'h120); chk("R8 output pin ignored", rd_u, 0);
      p0 = 8'h42; settle();
      bus_read(9'h120); chk("R8 rising", rd_u, 1);
      bus_write(9'h120, 32'h1, 4'hF);
      bus_read(9'h120); chk("R9 cleared", rd_u, 0);
      p0 = 8'h40; settle();
      bus_read(9'h120); chk("R8 falling", rd_u, 1);
      bus_write(9'h120, 32'h1, 4'hF);
      p1 = 5'h10; settle();
      bus_read(9'h120); chk("R8 channel1", rd_u, 2);
      bus_write(9'h120, 32'h0, 4'hF);
      bus_read(9'h120); chk("R9 write zero keeps", rd_u, 2);
      bus_write(9'h120, 32'h1, 4'hF);
      bus_read(9'h120); chk("R9 other bit kept", rd_u, 2);
      exp_stat = 2'b10;

      // R10 interrupt gating
      bus_write(9'h128, 32'h1, 4'hF); exp_ena = 2'b01;
      chk("R10 no gie", 32'(irq_u), 0);
      bus_write(9'h11C, 32'h8000_0000, 4'hF); exp_gie = 1;
      bus_read(9'h11C); chk("R10 gie read", rd_u, 32'h8000_0000);
      chk("R10 enable mismatch", 32'(irq_u), 0);
      bus_write(9'h128, 32'h2, 4'hF); exp_ena = 2'b10;
      chk("R10 asserted", 32'(irq_u), 1);
      chk("R11 irq absent", 32'(irq_m), 0);
      bus_write(9'h11C, 32'h0, 4'hF); exp_gie = 0;
      chk("R10 gie off", 32'(irq_u), 0);

      // R12 responses and unmapped space
      bus_read(9'h010); chk("R12 unmapped", rd_u, 0);
      chk("R12 rresp", 32'(last_rresp), 0);
      bus_read(9'h124); chk("R12 unmapped 124", rd_u, 0);
      chk("R12 bresp", 32'(last_bresp), 0);
      chk("R12 bvalid", 32'(last_bvalid), 1);

      bus_write(9'h11C, 32'h8000_0000, 4'hF); exp_gie = 1;
      bus_write(9'h128, 32'h3, 4'hF); exp_ena = 2'b11;

      // R2 R3 R8 R9 R10 constrained random
      for (int i = 0; i < 60; i++) begin
         logic [31:0] r_dir, r_out, clr;
         logic [3:0]  s_dir, s_out;
         logic [7:0]  n0;
         logic [4:0]  n1;
         logic        f0, f1;
         r_dir = $urandom; r_out = $urandom;
         s_dir = 4'($urandom); s_out = 4'($urandom);
         bus_write(9'h004, r_dir, s_dir);
         exp_dir0 = 8'(merge(32'(exp_dir0), r_dir, s_dir));
         bus_write(9'h000, r_out, s_out);
         exp_out0 = 8'(merge(32'(exp_out0), r_out, s_out));
         exp_mout = 4'(merge(32'(exp_mout), r_out, s_out));
         n0 = 8'($urandom); n1 = 5'($urandom);
         if (i % 4 == 0) n1 = p1;
         f0 = |((p0 ^ n0) & exp_dir0);
         f1 = (p1 != n1);
         @(negedge clk);
         p0 = n0; p1 = n1; q0 = 4'($urandom);
         settle();
         exp_stat = exp_stat | {f1, f0};
         chk("R2 ch0_out", 32'(c0_out), 32'(exp_out0));
         chk("R3 ch0_hiz", 32'(c0_hiz), 32'(exp_dir0));
         bus_read(9'h000);
         chk("R2 data view", rd_u, 32'(view0(exp_dir0, exp_out0, p0)));
         chk("R6 latch view", rd_m, 32'(exp_mout));
         bus_read(9'h004); chk("R3 dir read", rd_u, 32'(exp_dir0));
         bus_read(9'h008); chk("R5 input view", rd_u, 32'(p1));
         bus_read(9'h120); chk("R8 status", rd_u, 32'(exp_stat));
         chk("R10 irq", 32'(irq_u), 32'(exp_irq()));
         clr = $urandom & 32'h3;
         bus_write(9'h120, clr, 4'hF);
         exp_stat = exp_stat & ~clr[1:0];
         bus_read(9'h120); chk("R9 after clear", rd_u, 32'(exp_stat));
         chk("R10 irq after clear", 32'(irq_u), 32'(exp_irq()));
      end

      finish_run();
   end

endmodule